// File: doc/BRIEF.md
# Video Control Register Slave on I2C

This block is a write-only I2C slave that holds the control settings of a video output path. It runs on a fast system clock and oversamples the SCL and SDA lines. A bus master programs it with one short transaction: START, the device address with the write bit, a register subaddress, one data byte, then STOP. The slave acknowledges each byte by pulling SDA low through an open-drain enable. It never returns data.

Three 8-bit registers are decoded straight into parallel control fields for the video path: the input format select, the chroma number coding, the keying mode, the key enable and key polarity, the key delay and the key compare byte. A register takes a new value only once its data byte has been fully received and acknowledged. A synchronous active-low reset clears every field to zero.

Top module: `vidctl_i2c_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, every control output and `sda_oe` are cleared to 0.
- R2: After a START, the first byte is compared with address 7'b1011111 followed by the write bit 0 (byte value 8'hBE). On a match the slave pulls SDA low during the ninth SCL pulse of the address byte, the subaddress byte and the data byte.
- R3: If the first byte holds a different address, or has the read bit 1, the slave gives no acknowledge and ignores every following bit up to the next START. No register changes.
- R4: Subaddress 0 holds these fields: `key_mode` = bits 7..5, `chroma_bin` = bit 4 (0 = two's complement chroma, 1 = offset binary), `key_en` = bit 3, `key_inv` = bit 2, `fmt_sel` = bits 1..0.
- R5: Subaddress 1 holds `key_dly` in bits 2..0. Bits 7..3 of the data byte are discarded.
- R6: Subaddress 2 holds the 8-bit `key_val` compare byte.
- R7: A subaddress above 2 is acknowledged, as is its data byte. The data byte changes no output.
- R8: A register updates only after the acknowledge of its data byte has ended. A STOP or START that arrives before that point leaves every output unchanged.
- R9: A repeated START at any point restarts address reception. A following complete write takes effect normally.
- R10: `sda_oe` is high only during acknowledge bits. It changes only while SCL is low, and it is low after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| fmt_sel | output | 2 | Video input format select |
| chroma_bin | output | 1 | Chroma coding: 1 offset binary, 0 two's complement |
| key_mode | output | 3 | Keying mode select |
| key_en | output | 1 | Key enable |
| key_inv | output | 1 | Key polarity invert |
| key_dly | output | 3 | Key delay in pixel clocks |
| key_val | output | 8 | Key compare byte |

## Verification
The bench stresses the address filter with read requests and near-miss addresses. A design that compares only seven bits would acknowledge a read, and one that forgets to go idle would later latch stray bytes into a register. Writes that stop after five data bits show whether the design commits a register too early, which would expose a half-shifted byte on the outputs. Out-of-range subaddresses, masked bits in the delay register and repeated STARTs catch a register file that wraps the subaddress, keeps high bits, or loses its place in the frame. Random transactions mixed with these cases must keep every output equal to a model of the three registers.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int NUM_REGS = 3;
    localparam int DLY_W    = 3;
    localparam int BIT_CW   = $clog2(BYTE_W + 1);
    localparam logic [ADDR_W-1:0] DEV_ADDR = 7'b1011111;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_ACK,
        ST_IGNORE
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic [2:0]       key_mode;
        logic             chroma_bin;
        logic             key_en;
        logic             key_inv;
        logic [1:0]       fmt_sel;
        logic [DLY_W-1:0] key_dly;
        logic [BYTE_W-1:0] key_val;
    } ctl_fields_t;

    function automatic logic is_write_to_me(input logic [BYTE_W-1:0] b);
        return b == {DEV_ADDR, 1'b0};
    endfunction

    function automatic logic [BYTE_W-1:0] reg_mask(input int idx);
        return (idx == 1) ? BYTE_W'((1 << DLY_W) - 1) : {BYTE_W{1'b1}};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import vidctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_q[g] <= scl_i;
                    sda_q[g] <= sda_i;
                end else begin
                    scl_q[g] <= scl_q[(g == 0) ? 0 : g-1];
                    sda_q[g] <= sda_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    logic scl_s;
    logic sda_s;
    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        evt.start    = scl_s & scl_p & sda_p & ~sda_s;
        evt.stop     = scl_s & scl_p & ~sda_p & sda_s;
        evt.scl_rise = scl_s & ~scl_p;
        evt.scl_fall = ~scl_s & scl_p;
        evt.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import vidctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output rx_state_e         state
);

    logic [BYTE_W-1:0] shreg;
    logic [BIT_CW-1:0] bitcnt;
    rx_state_e         ack_next;
    logic              byte_done;

    assign byte_done = evt.scl_fall && (bitcnt == BIT_CW'(BYTE_W));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack_next <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_SUB, ST_DATA: begin
                        if (evt.scl_rise && bitcnt < BIT_CW'(BYTE_W)) begin
                            shreg  <= {shreg[BYTE_W-2:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end
                        if (byte_done) begin
                            if (state == ST_ADDR) begin
                                if (is_write_to_me(shreg)) begin
                                    sda_oe   <= 1'b1;
                                    ack_next <= ST_SUB;
                                    state    <= ST_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_SUB) begin
                                wr_addr  <= shreg;
                                sda_oe   <= 1'b1;
                                ack_next <= ST_DATA;
                                state    <= ST_ACK;
                            end else begin
                                wr_data  <= shreg;
                                sda_oe   <= 1'b1;
                                ack_next <= ST_IGNORE;
                                state    <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ack_next;
                            if (ack_next == ST_IGNORE) wr_stb <= 1'b1;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
    import vidctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output ctl_fields_t       fields
);

    logic [BYTE_W-1:0] regs [NUM_REGS];

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[g] <= '0;
                end else if (wr_stb && wr_addr == BYTE_W'(g)) begin
                    regs[g] <= wr_data & reg_mask(g);
                end
            end
        end
    endgenerate

    always_comb begin
        fields.key_mode   = regs[0][7:5];
        fields.chroma_bin = regs[0][4];
        fields.key_en     = regs[0][3];
        fields.key_inv    = regs[0][2];
        fields.fmt_sel    = regs[0][1:0];
        fields.key_dly    = regs[1][DLY_W-1:0];
        fields.key_val    = regs[2];
    end

endmodule

// File: rtl/vidctl_i2c_regs.sv
module vidctl_i2c_regs
    import vidctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [1:0] fmt_sel,
    output logic       chroma_bin,
    output logic [2:0] key_mode,
    output logic       key_en,
    output logic       key_inv,
    output logic [2:0] key_dly,
    output logic [7:0] key_val
);

    bus_evt_t          evt;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    rx_state_e         fsm_state;
    ctl_fields_t       fields;

    i2c_line_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_rx_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .sda_oe  (sda_oe),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state   (fsm_state)
    );

    ctl_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fields  (fields)
    );

    assign fmt_sel    = fields.fmt_sel;
    assign chroma_bin = fields.chroma_bin;
    assign key_mode   = fields.key_mode;
    assign key_en     = fields.key_en;
    assign key_inv    = fields.key_inv;
    assign key_dly    = fields.key_dly;
    assign key_val    = fields.key_val;

endmodule

// File: rtl/vidctl_i2c_regs_chk.sv
module vidctl_i2c_regs_chk
    import vidctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              stop_det,
    input logic              wr_stb,
    input logic [BYTE_W-1:0] wr_addr,
    input rx_state_e         fsm_state,
    input ctl_fields_t       fields
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fields == '0 && !sda_oe));

    // R8
    hold_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(fields));

    // R7
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr >= BYTE_W'(NUM_REGS)) |=> $stable(fields));

    // R3
    silent_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE || fsm_state == ST_IDLE) |-> !sda_oe);

    // R10
    sda_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R10
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

bind vidctl_i2c_regs vidctl_i2c_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .stop_det  (evt.stop),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .fsm_state (fsm_state),
    .fields    (fields)
);

// File: tb/vidctl_i2c_regs_bench.sv
`timescale 1ns/1ps
module vidctl_i2c_regs_bench;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe;
    logic       sda_line;
    logic [1:0] fmt_sel;
    logic       chroma_bin;
    logic [2:0] key_mode;
    logic       key_en;
    logic       key_inv;
    logic [2:0] key_dly;
    logic [7:0] key_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit drove_in_data = 0;

    logic [7:0] model [3];

    always #2 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    vidctl_i2c_regs u_vidctl_i2c_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .fmt_sel    (fmt_sel),
        .chroma_bin (chroma_bin),
        .key_mode   (key_mode),
        .key_en     (key_en),
        .key_inv    (key_inv),
        .key_dly    (key_dly),
        .key_val    (key_val)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [18:0] exp_vec();
        return {model[0], model[1][2:0], model[2]};
    endfunction

    function automatic logic [18:0] got_vec();
        return {key_mode, chroma_bin, key_en, key_inv, fmt_sel, key_dly, key_val};
    endfunction

    task automatic bus_start();
        tick(Q); m_sda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(2*Q); m_sda = 1'b0;
        tick(2*Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); m_sda = 1'b0;
        tick(Q); scl = 1'b1;
        tick(2*Q); m_sda = 1'b1;
        tick(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            tick(Q); m_sda = b[i];
            tick(Q); scl = 1'b1;
            tick(Q); if (sda_oe) drove_in_data = 1;
            tick(Q); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        tick(Q); m_sda = 1'b1;
        tick(Q); scl = 1'b1;
        tick(Q); ack = ~sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic write_txn(input logic [7:0] first, input logic [7:0] sub,
                             input logic [7:0] data, output logic [2:0] acks);
        logic a;
        bus_start();
        send_byte(first, a); acks[2] = a;
        send_byte(sub, a);   acks[1] = a;
        send_byte(data, a);  acks[0] = a;
        bus_stop();
        tick(4);
    endtask

    function automatic void model_write(input logic [7:0] first, input logic [7:0] sub,
                                        input logic [7:0] data);
        if (first == 8'hBE && sub < 3)
            model[sub] = (sub == 1) ? (data & 8'h07) : data;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic       a;
        void'($urandom(32'd7167));
        for (int i = 0; i < 3; i++) model[i] = 8'h00;

        tick(5);
        // R1 reset state
        check("R1", {13'd0, got_vec()}, 32'd0);
        check("R1 sda_oe", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        tick(5);

        // R2 R4 register 0 field map
        write_txn(8'hBE, 8'h00, 8'hA5, acks);
        model_write(8'hBE, 8'h00, 8'hA5);
        check("R2 acks", {29'd0, acks}, 32'h7);
        check("R4 key_mode", {29'd0, key_mode}, 32'h5);
        check("R4 chroma_bin", {31'd0, chroma_bin}, 32'h0);
        check("R4 key_en", {31'd0, key_en}, 32'h0);
        check("R4 key_inv", {31'd0, key_inv}, 32'h1);
        check("R4 fmt_sel", {30'd0, fmt_sel}, 32'h1);
        write_txn(8'hBE, 8'h00, 8'h1A, acks);
        model_write(8'hBE, 8'h00, 8'h1A);
        check("R4 vec", {13'd0, got_vec()}, {13'd0, exp_vec()});

        // R5 delay with masked upper bits
        write_txn(8'hBE, 8'h01, 8'hFD, acks);
        model_write(8'hBE, 8'h01, 8'hFD);
        check("R5 key_dly", {29'd0, key_dly}, 32'h5);
        check("R5 vec", {13'd0, got_vec()}, {13'd0, exp_vec()});

        // R6 key value
        write_txn(8'hBE, 8'h02, 8'h3C, acks);
        model_write(8'hBE, 8'h02, 8'h3C);
        check("R6 key_val", {24'd0, key_val}, 32'h3C);

        // R3 read request and wrong address
        write_txn(8'hBF, 8'h02, 8'h99, acks);
        check("R3 read acks", {29'd0, acks}, 32'h0);
        check("R3 read regs", {13'd0, got_vec()}, {13'd0, exp_vec()});
        write_txn(8'hBC, 8'h00, 8'hFF, acks);
        check("R3 addr acks", {29'd0, acks}, 32'h0);
        check("R3 addr regs", {13'd0, got_vec()}, {13'd0, exp_vec()});

        // R7 out of range subaddress
        write_txn(8'hBE, 8'h03, 8'hFF, acks);
        check("R7 acks", {29'd0, acks}, 32'h7);
        check("R7 regs", {13'd0, got_vec()}, {13'd0, exp_vec()});
        write_txn(8'hBE, 8'h82, 8'h11, acks);
        check("R7 high sub regs", {13'd0, got_vec()}, {13'd0, exp_vec()});

        // R8 abort before the data byte completes
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h02, a);
        send_bits(8'h00, 5);
        bus_stop();
        tick(4);
        check("R8 stop abort", {13'd0, got_vec()}, {13'd0, exp_vec()});
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h00, a);
        send_byte(8'h42, a);
        check("R8 before ack end", {13'd0, got_vec()}, {13'd0, exp_vec()});
        bus_stop();
        tick(4);
        model_write(8'hBE, 8'h00, 8'h42);
        check("R8 after ack", {13'd0, got_vec()}, {13'd0, exp_vec()});

        // R9 repeated start
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hBE, a);
        send_byte(8'h02, a);
        send_byte(8'hC7, a);
        check("R9 ack", {31'd0, a}, 32'h1);
        bus_stop();
        tick(4);
        model_write(8'hBE, 8'h02, 8'hC7);
        check("R9 regs", {13'd0, got_vec()}, {13'd0, exp_vec()});

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [7:0] first;
            logic [7:0] sub;
            logic [7:0] data;
            logic [2:0] exp_ack;
            case ($urandom % 4)
                0: first = 8'hBF;
                1: first = 8'($urandom);
                default: first = 8'hBE;
            endcase
            sub  = 8'($urandom % 5);
            data = 8'($urandom);
            write_txn(first, sub, data, acks);
            model_write(first, sub, data);
            exp_ack = (first == 8'hBE) ? 3'h7 : 3'h0;
            check("R2 R3 random acks", {29'd0, acks}, {29'd0, exp_ack});
            check("R4 R5 R6 R7 random regs", {13'd0, got_vec()}, {13'd0, exp_vec()});
        end

        // R10 release outside acknowledge
        check("R10 data bits", {31'd0, drove_in_data}, 32'h0);
        check("R10 after stop", {31'd0, sda_oe}, 32'h0);

        // R1 reset mid-run
        rst_n = 1'b0;
        tick(3);
        check("R1 re-reset", {13'd0, got_vec()}, 32'd0);
        rst_n = 1'b1;
        tick(3);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule